// File: doc/BRIEF.md
# Tag Frame Parser

This block sits behind a bit-level demodulator in a low-frequency tag reader. Each incoming bit comes with a one-cycle valid strobe. The parser first hunts for a run of nine ones that opens a 64-bit frame. It then gathers ten five-bit rows, each made of a 4-bit nibble and an even-parity bit. After the rows it reads a 4-bit column-parity word, which must equal the XOR of all ten nibbles, and last a stop bit, which must be zero.

When a frame is clean, the parser puts the ten nibbles on a packed output and raises a ready flag. It then stops listening until the consumer pulses an acknowledge. Any fault during a frame, whether a short header, a bad row, a wrong column word or a high stop bit, sends the parser straight back to hunting. A faulty frame leaves the output untouched.

Top module: `tag_frame_parser`

## Requirements
- R1: While reset is held and right after it is released, frame_ready is 0 and nibbles is all zeros.
- R2: While hunting, a valid zero leaves the parser hunting. A valid one starts the header. A frame is accepted only after nine consecutive valid ones.
- R3: A valid zero inside the header returns the parser to hunting. Eight ones followed by a zero produce no frame.
- R4: Each row is four data bits, most significant first, followed by one parity bit. The XOR of all five bits must be 0. A row that fails this check abandons the frame.
- R5: After the tenth row, four bits arrive, most significant first. They must equal the bitwise XOR of the ten row nibbles, or the frame is abandoned.
- R6: The bit after the column word must be 0. A 1 in that position abandons the frame.
- R7: On a valid zero stop bit, frame_ready is 1 from the next cycle. nibbles then holds row 0 in bits 39:36, row 1 in bits 35:32, and so on down to row 9 in bits 3:0.
- R8: While frame_ready is 1, valid bits are ignored. Even a complete further frame leaves frame_ready and nibbles unchanged.
- R9: An ack while frame_ready is 1 clears frame_ready in the next cycle and restarts hunting. An ack while hunting has no effect.
- R10: nibbles changes only when a frame completes. It keeps its value through acknowledges and through abandoned frames.
- R11: Cycles with bit_valid low are ignored, however many of them fall between the bits of a frame.
- R12: The bit that causes an abandon is not reused. A clean frame that follows a faulty one, separated by at least one zero, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe marking a new demodulated bit |
| bit_value | input | 1 | The bit value, sampled when bit_valid is 1 |
| ack | input | 1 | Consumer has taken the frame |
| frame_ready | output | 1 | A checked frame is held on nibbles |
| nibbles | output | 40 | Ten 4-bit row values, row 0 in the top nibble |

## Verification
A corrupted bit counter or row index in this parser shows up at the ports within one frame. A genuine frame is then either dropped or delivered with its nibbles shifted, so the scoreboard sees a missing or mismatched frame at the next rise of frame_ready. A stale parity register has the same reach: it rejects clean frames or accepts faulty ones at the row or column boundary where it is consulted. A hold state that lets bits through, or an output register that loads outside completion, appears as soon as traffic is sent during hold or after an abandoned frame. The bench therefore sends such traffic and compares nibbles right afterwards.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_HDR  = 3'd1,
    ST_ROW  = 3'd2,
    ST_COL  = 3'd3,
    ST_STOP = 3'd4,
    ST_HOLD = 3'd5
  } tfp_state_e;
endpackage

// File: rtl/tfp_ctrl.sv
module tfp_ctrl
  import tfp_pkg::*;
#(
  parameter int HDR_ONES = 9,
  parameter int NROWS    = 10,
  parameter int NIB_W    = 4,
  localparam int ROW_BITS = NIB_W + 1,
  localparam int CNT_MAX  = (HDR_ONES > ROW_BITS) ? HDR_ONES : ROW_BITS,
  localparam int CW       = $clog2(CNT_MAX + 1),
  localparam int RW       = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          bit_value,
  input  logic          ack,
  input  logic          row_ok,
  input  logic          col_match,
  output logic          clr_all,
  output logic          shift_en,
  output logic          row_end,
  output logic          slot_wr,
  output logic [RW-1:0] row_idx,
  output logic          commit,
  output logic          frame_ready
);

  tfp_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] row_q, row_d;
  logic          last_bit;
  logic          step;

  assign last_bit    = (cnt_q == CW'(1));
  assign step        = bit_valid | ack;
  assign row_idx     = row_q;
  assign frame_ready = (st_q == ST_HOLD);

  // next-state process
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    row_d    = row_q;
    clr_all  = 1'b0;
    shift_en = 1'b0;
    row_end  = 1'b0;
    slot_wr  = 1'b0;
    commit   = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (bit_valid && bit_value) begin
          st_d  = ST_HDR;
          cnt_d = CW'(HDR_ONES - 1);
        end
      end
      ST_HDR: begin
        if (bit_valid) begin
          if (!bit_value) begin
            st_d = ST_HUNT;
          end else if (last_bit) begin
            st_d    = ST_ROW;
            cnt_d   = CW'(ROW_BITS);
            row_d   = '0;
            clr_all = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      ST_ROW: begin
        if (bit_valid) begin
          if (last_bit) begin
            row_end = 1'b1;
            if (!row_ok) begin
              st_d = ST_HUNT;
            end else begin
              slot_wr = 1'b1;
              if (row_q == RW'(NROWS - 1)) begin
                st_d  = ST_COL;
                cnt_d = CW'(NIB_W);
              end else begin
                row_d = row_q + 1'b1;
                cnt_d = CW'(ROW_BITS);
              end
            end
          end else begin
            shift_en = 1'b1;
            cnt_d    = cnt_q - 1'b1;
          end
        end
      end
      ST_COL: begin
        if (bit_valid) begin
          if (last_bit) begin
            st_d = col_match ? ST_STOP : ST_HUNT;
          end else begin
            shift_en = 1'b1;
            cnt_d    = cnt_q - 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (bit_valid) begin
          if (!bit_value) begin
            st_d   = ST_HOLD;
            commit = 1'b1;
          end else begin
            st_d = ST_HUNT;
          end
        end
      end
      ST_HOLD: begin
        if (ack) st_d = ST_HUNT;
      end
      default: st_d = ST_HUNT;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
      row_q <= '0;
    end else if (step) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
    end
  end

  a_r2_hunt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT && bit_valid && !bit_value) |=> (st_q == ST_HUNT));
  a_r4_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= RW'(NROWS - 1));
  a_r7_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_ready) |-> $past(st_q == ST_STOP && bit_valid && !bit_value));
  a_r8_ready_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && !ack) |=> frame_ready);
  a_r9_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ready && ack) |=> !frame_ready);

endmodule

// File: rtl/tfp_parity.sv
module tfp_parity #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             shift_en,
  input  logic             row_end,
  input  logic             bit_value,
  output logic [NIB_W-1:0] acc,
  output logic             row_ok,
  output logic             col_match
);

  logic [NIB_W-1:0] acc_q, acc_d;
  logic [NIB_W-1:0] cpar_q, cpar_d;
  logic             rpar_q, rpar_d;
  logic             upd;

  assign acc       = acc_q;
  assign row_ok    = ~(rpar_q ^ bit_value);
  assign col_match = ({acc_q[NIB_W-2:0], bit_value} == cpar_q);
  assign upd       = clr_all | row_end | shift_en;

  always_comb begin
    acc_d  = acc_q;
    cpar_d = cpar_q;
    rpar_d = rpar_q;
    if (clr_all) begin
      acc_d  = '0;
      cpar_d = '0;
      rpar_d = 1'b0;
    end else if (row_end) begin
      acc_d  = '0;
      rpar_d = 1'b0;
      if (row_ok) cpar_d = cpar_q ^ acc_q;
    end else if (shift_en) begin
      acc_d  = {acc_q[NIB_W-2:0], bit_value};
      rpar_d = rpar_q ^ bit_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cpar_q <= '0;
      rpar_q <= 1'b0;
    end else if (upd) begin
      acc_q  <= acc_d;
      cpar_q <= cpar_d;
      rpar_q <= rpar_d;
    end
  end

  a_r5_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (acc_q == '0 && cpar_q == '0 && rpar_q == 1'b0));
  a_r4_row_restart: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> (acc_q == '0 && rpar_q == 1'b0));

endmodule

// File: rtl/tfp_slots.sv
module tfp_slots #(
  parameter int NROWS = 10,
  parameter int NIB_W = 4,
  localparam int RW   = (NROWS > 1) ? $clog2(NROWS) : 1,
  localparam int OW   = NROWS * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_wr,
  input  logic [RW-1:0]    row_idx,
  input  logic [NIB_W-1:0] acc,
  input  logic             commit,
  output logic [OW-1:0]    nibbles
);

  logic [OW-1:0] stage_flat;
  logic [OW-1:0] out_q;

  for (genvar i = 0; i < NROWS; i++) begin : g_slot
    logic [NIB_W-1:0] stage_q;
    logic             wr_here;
    assign wr_here = slot_wr && (row_idx == RW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else if (wr_here) stage_q <= acc;
    end
    assign stage_flat[(NROWS-1-i)*NIB_W +: NIB_W] = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (commit) out_q <= stage_flat;
  end

  assign nibbles = out_q;

  a_r10_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(out_q));

endmodule

// File: rtl/tag_frame_parser.sv
module tag_frame_parser #(
  parameter int HDR_ONES = 9,
  parameter int NROWS    = 10,
  parameter int NIB_W    = 4,
  localparam int RW      = (NROWS > 1) ? $clog2(NROWS) : 1,
  localparam int OW      = NROWS * NIB_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          bit_value,
  input  logic          ack,
  output logic          frame_ready,
  output logic [OW-1:0] nibbles
);

  logic             clr_all, shift_en, row_end, slot_wr, commit;
  logic             row_ok, col_match;
  logic [RW-1:0]    row_idx;
  logic [NIB_W-1:0] acc;

  tfp_ctrl #(.HDR_ONES(HDR_ONES), .NROWS(NROWS), .NIB_W(NIB_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
    .ack(ack), .row_ok(row_ok), .col_match(col_match), .clr_all(clr_all),
    .shift_en(shift_en), .row_end(row_end), .slot_wr(slot_wr),
    .row_idx(row_idx), .commit(commit), .frame_ready(frame_ready)
  );

  tfp_parity #(.NIB_W(NIB_W)) par_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .shift_en(shift_en),
    .row_end(row_end), .bit_value(bit_value), .acc(acc), .row_ok(row_ok),
    .col_match(col_match)
  );

  tfp_slots #(.NROWS(NROWS), .NIB_W(NIB_W)) slots_i (
    .clk(clk), .rst_n(rst_n), .slot_wr(slot_wr), .row_idx(row_idx),
    .acc(acc), .commit(commit), .nibbles(nibbles)
  );

endmodule

// File: tb/tag_frame_parser_tb_top.sv
module tag_frame_parser_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_value = 1'b0;
  logic        ack = 1'b0;
  logic        frame_ready;
  logic [39:0] nibbles;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [39:0] exp_q[$];
  logic        rdy_prev = 1'b0;

  always #4 clk = ~clk;

  tag_frame_parser dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
    .ack(ack), .frame_ready(frame_ready), .nibbles(nibbles)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 clean, 1 bad row parity, 2 bad column word, 3 high stop, 4 short header
  function automatic logic [63:0] mk_frame(input logic [39:0] d, input int kind);
    logic [63:0] f;
    logic [3:0]  cp;
    logic [3:0]  n;
    logic        par;
    int          p;
    f = '0;
    p = 63;
    cp = '0;
    for (int i = 0; i < 9; i++) begin
      f[p] = (kind == 4 && i == 8) ? 1'b0 : 1'b1;
      p--;
    end
    for (int r = 0; r < 10; r++) begin
      n = d[(9-r)*4 +: 4];
      for (int b = 3; b >= 0; b--) begin
        f[p] = n[b];
        p--;
      end
      par = ^n;
      if (kind == 1 && r == 3) par = ~par;
      f[p] = par;
      p--;
      cp = cp ^ n;
    end
    if (kind == 2) cp[0] = ~cp[0];
    for (int b = 3; b >= 0; b--) begin
      f[p] = cp[b];
      p--;
    end
    f[p] = (kind == 3);
    return f;
  endfunction

  task automatic put_bit(input logic b, input int gap);
    bit_valid = 1'b1;
    bit_value = b;
    @(negedge clk);
    bit_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // driver: leading zero separator, then the 64 bits; clean frames are scoreboarded
  task automatic send_frame(input logic [39:0] d, input int kind,
                            input bit expect_out, input int gap);
    logic [63:0] f;
    f = mk_frame(d, kind);
    if (kind == 0 && expect_out) exp_q.push_back(d);
    put_bit(1'b0, 0);
    for (int i = 63; i >= 0; i--) put_bit(f[i], (i == 0) ? 0 : gap);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(frame_ready == 1'b0, "R9 ack clears ready", 64'(frame_ready), 64'd0);
  endtask

  // monitor: each rise of frame_ready pops one expected frame
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_ready && !rdy_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected frame", 64'(nibbles), 64'd0);
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk(nibbles == e, "R7 nibble order", 64'(nibbles), 64'(e));
        end
      end
      rdy_prev <= frame_ready;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk);
    chk(frame_ready == 1'b0 && nibbles == '0, "R1 reset state", 64'(nibbles), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_ready == 1'b0 && nibbles == '0, "R1 after release", 64'(nibbles), 64'd0);

    // R9: ack while hunting, R2: zeros while hunting
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    for (int i = 0; i < 5; i++) put_bit(1'b0, 0);
    chk(frame_ready == 1'b0, "R2 zeros keep hunting", 64'(frame_ready), 64'd0);

    // R7: clean frame, ready right after the stop bit
    send_frame(40'h1A2B3C4D5E, 0, 1'b1, 0);
    chk(frame_ready == 1'b1, "R7 ready after stop", 64'(frame_ready), 64'd1);
    held = 40'h1A2B3C4D5E;

    // R8: traffic in hold is ignored, including a whole clean frame
    for (int i = 0; i < 12; i++) put_bit(i[0], 0);
    chk(frame_ready == 1'b1 && nibbles == held, "R8 bits in hold", 64'(nibbles), 64'(held));
    send_frame(40'h9876543210, 0, 1'b0, 0);
    chk(frame_ready == 1'b1 && nibbles == held, "R8 frame in hold", 64'(nibbles), 64'(held));
    do_ack();
    chk(nibbles == held, "R10 kept after ack", 64'(nibbles), 64'(held));

    // R4: bad row parity
    send_frame(40'h0123456789, 1, 1'b0, 0);
    repeat (2) @(negedge clk);
    chk(frame_ready == 1'b0 && nibbles == held, "R4 row parity abandon", 64'(nibbles), 64'(held));

    // R5: bad column word
    send_frame(40'hFEDCBA9876, 2, 1'b0, 0);
    repeat (2) @(negedge clk);
    chk(frame_ready == 1'b0 && nibbles == held, "R5 column abandon", 64'(nibbles), 64'(held));

    // R6: high stop bit
    send_frame(40'h5555AAAA77, 3, 1'b0, 0);
    repeat (2) @(negedge clk);
    chk(frame_ready == 1'b0 && nibbles == held, "R6 stop abandon", 64'(nibbles), 64'(held));

    // R12: clean frame right after the faulty one
    send_frame(40'h2468ACE135, 0, 1'b1, 0);
    chk(frame_ready == 1'b1, "R12 recovery frame", 64'(frame_ready), 64'd1);
    held = 40'h2468ACE135;
    do_ack();

    // R3: eight ones then zero
    send_frame(40'h3141592653, 4, 1'b0, 0);
    repeat (2) @(negedge clk);
    chk(frame_ready == 1'b0 && nibbles == held, "R3 short header", 64'(nibbles), 64'(held));

    // R11: gaps between bits
    send_frame(40'hB0D1E2F3A4, 0, 1'b1, 3);
    chk(frame_ready == 1'b1, "R11 gapped frame", 64'(frame_ready), 64'd1);
    do_ack();

    // R2: leading zeros then boundary data patterns
    for (int i = 0; i < 7; i++) put_bit(1'b0, 1);
    send_frame(40'h0000000000, 0, 1'b1, 0);
    chk(frame_ready == 1'b1 && nibbles == '0, "R2 all-zero frame", 64'(nibbles), 64'd0);
    do_ack();
    send_frame(40'hFFFFFFFFFF, 0, 1'b1, 1);
    chk(frame_ready == 1'b1 && nibbles == 40'hFFFFFFFFFF, "R7 all-ones frame",
        64'(nibbles), 64'hFFFFFFFFFF);
    do_ack();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all frames seen", 64'(exp_q.size()), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule